// File: doc/BRIEF.md
# Datapath Function Unit with Single-Position Shifter

This block is the arithmetic, logic and shift engine of a simple register-to-register datapath. Each cycle it accepts two operands, A and B, together with a 4-bit function code. It produces a result word and four status flags: overflow, carry, negative and zero. Inside, a ripple-carry arithmetic unit, a bitwise logic unit and a one-position shifter all work on the operands in parallel. A decoder turns the function code into select signals for each unit and for the output multiplexer.

The arithmetic unit always adds A to a selected second term: zero, B, the complement of B, or all ones. The low bit of the function code supplies the carry-in. The shifter works on B alone. It moves B one place right or left and fills the vacated end from a serial input. Both serial inputs are tied to zero, so every shift is logical. The result and the flags are captured in output registers. A synchronous, active-high reset clears these registers.

Top module: `func_unit`

## Requirements
- R1: Function codes 0x0 to 0x6 give, in that order: A, A+1, A+B, A+B+1, A+~B, A+~B+1, A-1, each modulo 2^WIDTH. C is the carry out of the most significant bit.
- R2: Function codes 0x7 and 0xB both give the bitwise complement of A.
- R3: Function code 0x8 gives A AND B, 0x9 gives A OR B, and 0xA gives A XOR B.
- R4: Function code 0xC gives B unchanged.
- R5: Function code 0xD gives B shifted right by one with a 0 entering the MSB. Function code 0xE gives B shifted left by one with a 0 entering the LSB.
- R6: For codes 0x0 to 0x6, V is 1 exactly when the carry into the MSB differs from the carry out of it. For every other code, both V and C are 0.
- R7: For every code, N equals the MSB of F, and Z is 1 exactly when F is all zeros.
- R8: Function code 0xF gives F = 0, and therefore Z = 1.
- R9: F, V, C, N and Z are registered. They show the result of the inputs sampled at the previous rising clock edge. When reset is high at a rising edge, all of them become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fs_i | input | 4 | Function select code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B (also the shifter input) |
| f_o | output | WIDTH | Registered result |
| v_o | output | 1 | Registered signed overflow flag |
| c_o | output | 1 | Registered carry flag |
| n_o | output | 1 | Registered negative flag |
| z_o | output | 1 | Registered zero flag |

## Verification
The bench builds the block with WIDTH = 16. At that width, hand-computed vectors can reach the exact carry chain boundaries: 0x7FFF+1 and 0x8000+0x8000 set V, and 0x8000-1 sets both V and C. At the same width, a walking one can be shifted through every bit position in one short loop, including the bit shifted out at each end. Flag-only corners are included too, such as a subtract of equal values that yields zero with carry set, and the unused code 0xF.

// File: rtl/fu_pkg.sv
package fu_pkg;

  // Second addend chosen for the arithmetic unit (function code bits 2:1)
  typedef enum logic [1:0] {
    YSEL_ZERO = 2'b00,
    YSEL_B    = 2'b01,
    YSEL_NOTB = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

  // Bitwise operation chosen for the logic unit
  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;

  // Per-bit shifter mux select
  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_NONE  = 2'b11
  } shsel_e;

  typedef struct packed {
    ysel_e  ysel;
    logic   cin;
    lop_e   lop;
    logic   logic_en;
    logic   mf;
    shsel_e hsel;
  } fsel_t;

  localparam int FS_W = 4;

endpackage

// File: rtl/fu_decode.sv
module fu_decode
  import fu_pkg::*;
(
  input  logic [FS_W-1:0] fs,
  output fsel_t           sel
);

  localparam logic [FS_W-1:0] FS_CMPL_A = 4'b0111;

  logic cmpl_a;

  assign cmpl_a = (fs == FS_CMPL_A);

  always_comb begin
    sel.ysel     = ysel_e'(fs[2:1]);
    sel.cin      = fs[0];
    sel.lop      = cmpl_a ? LOP_NOTA : lop_e'(fs[1:0]);
    sel.logic_en = fs[3] | cmpl_a;
    sel.mf       = fs[3] & fs[2];
    sel.hsel     = shsel_e'(fs[1:0]);
  end

endmodule

// File: rtl/fu_arith.sv
module fu_arith
  import fu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  ysel_e            ysel,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   cy;

  always_comb begin
    unique case (ysel)
      YSEL_ZERO: y = '0;
      YSEL_B:    y = b;
      YSEL_NOTB: y = ~b;
      default:   y = '1;
    endcase
  end

  assign cy[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]  = a[i] ^ y[i] ^ cy[i];
    assign cy[i+1] = (a[i] & y[i]) | (cy[i] & (a[i] ^ y[i]));
  end

  assign cout = cy[WIDTH];
  assign ovf  = cy[WIDTH] ^ cy[MSB];

endmodule

// File: rtl/fu_logic.sv
module fu_logic
  import fu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  lop_e             lop,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    unique case (lop)
      LOP_AND: res = a & b;
      LOP_OR:  res = a | b;
      LOP_XOR: res = a ^ b;
      default: res = ~a;
    endcase
  end

endmodule

// File: rtl/fu_shift.sv
module fu_shift
  import fu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] b,
  input  shsel_e           hsel,
  input  logic             ser_r,
  input  logic             ser_l,
  output logic [WIDTH-1:0] res
);

  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mux
    logic from_left;
    logic from_right;

    if (i == MSB) begin : g_top
      assign from_left = ser_r;
    end else begin : g_mid_r
      assign from_left = b[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_right = ser_l;
    end else begin : g_mid_l
      assign from_right = b[i-1];
    end

    always_comb begin
      unique case (hsel)
        SH_PASS:  res[i] = b[i];
        SH_RIGHT: res[i] = from_left;
        SH_LEFT:  res[i] = from_right;
        default:  res[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/func_unit.sv
module func_unit
  import fu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       fs_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] f_o,
  output logic             v_o,
  output logic             c_o,
  output logic             n_o,
  output logic             z_o
);

  localparam int MSB = WIDTH - 1;

  fsel_t            sel;
  logic [WIDTH-1:0] arith_f;
  logic [WIDTH-1:0] logic_f;
  logic [WIDTH-1:0] shift_f;
  logic [WIDTH-1:0] f_next;
  logic             arith_c;
  logic             arith_v;
  logic             arith_used;

  fu_decode u_decode (
    .fs  (fs_i),
    .sel (sel)
  );

  fu_arith #(.WIDTH(WIDTH)) u_arith (
    .a    (a_i),
    .b    (b_i),
    .ysel (sel.ysel),
    .cin  (sel.cin),
    .sum  (arith_f),
    .cout (arith_c),
    .ovf  (arith_v)
  );

  fu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (a_i),
    .b   (b_i),
    .lop (sel.lop),
    .res (logic_f)
  );

  fu_shift #(.WIDTH(WIDTH)) u_shift (
    .b     (b_i),
    .hsel  (sel.hsel),
    .ser_r (1'b0),
    .ser_l (1'b0),
    .res   (shift_f)
  );

  assign arith_used = ~sel.mf & ~sel.logic_en;

  always_comb begin
    if (sel.mf)            f_next = shift_f;
    else if (sel.logic_en) f_next = logic_f;
    else                   f_next = arith_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_o <= '0;
      v_o <= 1'b0;
      c_o <= 1'b0;
      n_o <= 1'b0;
      z_o <= 1'b0;
    end else begin
      f_o <= f_next;
      v_o <= arith_used & arith_v;
      c_o <= arith_used & arith_c;
      n_o <= f_next[MSB];
      z_o <= (f_next == '0);
    end
  end

  // ---------------- assertions ----------------
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (f_o == '0) && !v_o && !c_o && !n_o && !z_o);

  a_r1_add_b: assert property (@(posedge clk) disable iff (rst)
    (fs_i == 4'h2) |=> ({c_o, f_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  a_r2_cmpl_a: assert property (@(posedge clk) disable iff (rst)
    (fs_i == 4'h7 || fs_i == 4'hB) |=> (f_o == ~$past(a_i)));

  a_r4_pass_b: assert property (@(posedge clk) disable iff (rst)
    (fs_i == 4'hC) |=> (f_o == $past(b_i)));

  a_r5_shr: assert property (@(posedge clk) disable iff (rst)
    (fs_i == 4'hD) |=> (!f_o[MSB] && f_o[MSB-1:0] == $past(b_i[MSB:1])));

  a_r5_shl: assert property (@(posedge clk) disable iff (rst)
    (fs_i == 4'hE) |=> (!f_o[0] && f_o[MSB:1] == $past(b_i[MSB-1:0])));

  a_r6_no_carry_flags: assert property (@(posedge clk) disable iff (rst)
    (fs_i[3] || fs_i == 4'h7) |=> (!c_o && !v_o));

  a_r7_n_is_msb: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (n_o == f_o[MSB]));

  a_r7_z_is_zero: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (z_o == (f_o == '0)));

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (fs_i == 4'hF) |=> (f_o == '0 && z_o));

endmodule

// File: tb/test_func_unit.sv
module test_func_unit;

  localparam int W    = 16;
  localparam int NVEC = 20;

  logic         clk;
  logic         rst;
  logic [3:0]   fs;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [W-1:0] f;
  logic         v, c, n, z;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // entry: {fs, a, b, expected f, expected {v,c,n,z}}
  localparam logic [55:0] VEC [NVEC] = '{
    {4'h0, 16'h1234, 16'h0000, 16'h1234, 4'b0000}, // R1 transfer
    {4'h1, 16'hFFFF, 16'h0000, 16'h0000, 4'b0101}, // R1 increment wraps
    {4'h2, 16'h7FFF, 16'h0001, 16'h8000, 4'b1010}, // R1 R6 positive overflow
    {4'h3, 16'h0001, 16'h0002, 16'h0004, 4'b0000}, // R1 add plus one
    {4'h4, 16'h0005, 16'h0003, 16'h0001, 4'b0100}, // R1 A + ~B
    {4'h5, 16'h0005, 16'h0005, 16'h0000, 4'b0101}, // R1 subtract equal
    {4'h5, 16'h8000, 16'h0001, 16'h7FFF, 4'b1100}, // R1 R6 negative overflow
    {4'h6, 16'h0000, 16'h0000, 16'hFFFF, 4'b0010}, // R1 decrement zero
    {4'h7, 16'h00FF, 16'h1111, 16'hFF00, 4'b0010}, // R2
    {4'h8, 16'hF0F0, 16'hFF00, 16'hF000, 4'b0010}, // R3 and
    {4'h9, 16'hF0F0, 16'h0F0F, 16'hFFFF, 4'b0010}, // R3 or
    {4'hA, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b0001}, // R3 xor
    {4'hB, 16'hFFFF, 16'h0000, 16'h0000, 4'b0001}, // R2
    {4'hC, 16'h0000, 16'h8001, 16'h8001, 4'b0010}, // R4
    {4'hD, 16'hFFFF, 16'h8001, 16'h4000, 4'b0000}, // R5 right
    {4'hE, 16'hFFFF, 16'h8001, 16'h0002, 4'b0000}, // R5 left
    {4'hF, 16'hFFFF, 16'hFFFF, 16'h0000, 4'b0001}, // R8
    {4'h2, 16'hFFFF, 16'hFFFF, 16'hFFFE, 4'b0110}, // R1 carry no overflow
    {4'h2, 16'h8000, 16'h8000, 16'h0000, 4'b1101}, // R1 R6 carry and overflow
    {4'h6, 16'h8000, 16'h0000, 16'h7FFF, 4'b1100}  // R1 R6 decrement overflow
  };

  func_unit #(.WIDTH(W)) i_func_unit (
    .clk  (clk),
    .rst  (rst),
    .fs_i (fs),
    .a_i  (a),
    .b_i  (b),
    .f_o  (f),
    .v_o  (v),
    .c_o  (c),
    .n_o  (n),
    .z_o  (z)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_of(input logic [3:0] code);
    if (code <= 4'h6)                  return "R1";
    if (code == 4'h7 || code == 4'hB)  return "R2";
    if (code <= 4'hA)                  return "R3";
    if (code == 4'hC)                  return "R4";
    if (code == 4'hF)                  return "R8";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; fs = 4'h1; a = 16'hFFFF; b = 16'h0000;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset", {f, v, c, n, z}, {16'h0000, 4'b0000});
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      fs = VEC[i][55:52];
      a  = VEC[i][51:36];
      b  = VEC[i][35:20];
      @(negedge clk);
      check(req_of(VEC[i][55:52]), {16'h0, f}, {16'h0, VEC[i][19:4]});
      check("R6 R7 flags", {28'h0, v, c, n, z}, {28'h0, VEC[i][3:0]});
    end

    // R5: walking one through both shift directions
    for (int k = 0; k < W; k++) begin
      b  = 16'h0001 << k;
      fs = 4'hE;
      @(negedge clk);
      check("R5 left walk", {16'h0, f}, {16'h0, 16'(b << 1)});
      fs = 4'hD;
      @(negedge clk);
      check("R5 right walk", {16'h0, f}, {16'h0, 16'(b >> 1)});
    end

    // R9: output holds until the next rising edge
    fs = 4'h0; a = 16'h00AA; b = 16'h0;
    @(negedge clk);
    a = 16'h5500;
    #2;
    check("R9 latency hold", {16'h0, f}, {16'h0, 16'h00AA});
    @(negedge clk);
    check("R9 latency update", {16'h0, f}, {16'h0, 16'h5500});

    // R9: reset during operation wins over a result that would set flags
    fs = 4'h2; a = 16'h8000; b = 16'h8000; rst = 1'b1;
    @(negedge clk);
    check("R9 reset mid-run", {f, v, c, n, z}, {16'h0000, 4'b0000});
    rst = 1'b0;
    @(negedge clk);
    check("R6 after reset", {28'h0, v, c, n, z}, {28'h0, 4'b1101});

    finish_run();
  end

endmodule